// File: doc/BRIEF.md
# Priority Layer Blend Stack

This block composites up to 32 graphic layers into a single 24-bit RGB pixel stream. Each clock it receives, for every layer, an active flag, a colour, an 8-bit alpha and a blend-enable bit. Layers are ranked by index, and the highest index has the highest priority. At each pixel the block keeps the highest-ranked active layers, up to a global stack depth of 2 to 6. It treats the lowest of them as an opaque base and blends the rest on top of it, bottom to top. Every layer ranked below the base is hidden at that pixel. If no layer is active, the pixel takes a programmable background colour.

The depth and the background are written through a two-address register port. A new depth is first held as pending and reaches the datapath only at the next rising edge of the vertical sync input. A depth therefore never changes in the middle of a frame. The pixel path is a fixed-latency pipeline, and data-enable, horizontal sync and vertical sync are delayed by the same number of cycles so that they stay aligned with the colour.

Top module: `pixel_blend_stack`

## Requirements
- R1: Only the active layers with the highest indices take part in a pixel, and their number is limited to the active depth. A higher index always wins a stack slot over a lower one.
- R2: A layer whose active flag is low never affects the output pixel, whatever its colour, alpha or blend-enable bit.
- R3: The lowest-ranked selected layer is used as an opaque base. Its alpha and blend-enable bit are ignored. Every active layer ranked below it is invisible.
- R4: A selected layer above the base with blend-enable set gives, per 8-bit channel, round((a*src + (255-a)*dst)/255), where dst is the result of all the layers below it.
- R5: A selected layer above the base with blend-enable clear replaces the result with its own colour.
- R6: When fewer layers are active than the depth, all active layers are used, and the lowest active layer is the base.
- R7: When no layer is active, the output is the background colour. The background is written at cfgAddr=1 from cfgWdata[23:0] as {R,G,B}, with R in bits 23:16, and it resets to 0.
- R8: A write at cfgAddr=0 sets the pending depth only if the written value is in 2..6. Any other value is ignored. The depth resets to 6.
- R9: The pending depth is copied into the active depth only on a clock where inVsync is high and was low on the previous clock. Pixels before that clock use the old depth.
- R10: outColor, outValid, outHsync and outVsync each follow their inputs by exactly 7 clock cycles.
- R11: During and just after reset, outValid, outHsync, outVsync and outColor are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 1 | Register select: 0 for depth, 1 for background |
| cfgWdata | input | 24 | Register write data |
| inValid | input | 1 | Input data enable |
| inHsync | input | 1 | Input horizontal sync |
| inVsync | input | 1 | Input vertical sync; its rising edge marks a frame start |
| layerActive | input | 32 | Per-layer active flag at this pixel |
| layerColor | input | 768 | Per-layer colour; layer i is in bits [24i+23:24i] |
| layerAlpha | input | 256 | Per-layer alpha; layer i is in bits [8i+7:8i] |
| layerBlendEn | input | 32 | Per-layer blend enable |
| outValid | output | 1 | Delayed data enable |
| outHsync | output | 1 | Delayed horizontal sync |
| outVsync | output | 1 | Delayed vertical sync |
| outColor | output | 24 | Composited pixel {R,G,B} |

## Verification
The bench sweeps every legal depth with dense, sparse and empty layer patterns, random colours, and alphas that include the extremes 0 and 255. Each pixel is compared against an arithmetic model of the stack.

Several faults would show at the outputs:
- Honouring the base layer's alpha would blend it with the background instead of showing it opaque.
- Ranking by the wrong end of the index would show the wrong layer.
- An off-by-one in the slot limit would let a hidden layer show through. Directed pixels at depth 2 tell depth 2 apart from depth 3.
- A depth applied at write time instead of at the vsync edge would corrupt the pixels still streamed in the old frame.
- A depth outside 2..6 that was not rejected would change the stack.
- A sync signal delayed by a different number of stages than the colour would shift the raster against the pixels.

// File: rtl/blend_pkg.sv
package blend_pkg;

  localparam int STACK_LIMIT = 6;
  localparam int DEPTH_W     = $clog2(STACK_LIMIT + 1);
  localparam int CH_W        = 8;
  localparam int PIX_W       = 3 * CH_W;
  localparam int LATENCY     = STACK_LIMIT + 1;

  // Control fields handed from the control block to the datapath
  typedef struct packed {
    logic [DEPTH_W-1:0] depth;
    logic [PIX_W-1:0]   background;
  } dp_ctrl_t;

  // One selected entry of the per-pixel stack
  typedef struct packed {
    logic             valid;
    logic             isBase;
    logic             blendEn;
    logic [CH_W-1:0]  alpha;
    logic [PIX_W-1:0] color;
  } slot_t;

  // round((a*src + (255-a)*dst)/255) without a divider
  function automatic logic [CH_W-1:0] blendChannel(input logic [CH_W-1:0] alpha,
                                                   input logic [CH_W-1:0] src,
                                                   input logic [CH_W-1:0] dst);
    logic [16:0] mix;
    logic [16:0] biased;
    logic [16:0] folded;
    mix    = 17'(alpha) * 17'(src) + 17'(8'd255 - alpha) * 17'(dst);
    biased = mix + 17'd128;
    folded = (biased + (biased >> 8)) >> 8;
    return folded[CH_W-1:0];
  endfunction

endpackage

// File: rtl/blend_control.sv
module blend_control
  import blend_pkg::*;
#(
  parameter int DELAY = LATENCY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic             cfgAddr,
  input  logic [PIX_W-1:0] cfgWdata,
  input  logic             inValid,
  input  logic             inHsync,
  input  logic             inVsync,
  output dp_ctrl_t         dpCtrl,
  output logic             outValid,
  output logic             outHsync,
  output logic             outVsync
);

  logic [DEPTH_W-1:0] pendingDepth;
  logic [DEPTH_W-1:0] activeDepth;
  logic [PIX_W-1:0]   background;
  logic               vsyncPrev;
  logic               depthLegal;
  logic               frameStart;
  logic [2:0]         syncPipe [DELAY];

  assign depthLegal = (cfgWdata >= PIX_W'(2)) && (cfgWdata <= PIX_W'(STACK_LIMIT));
  assign frameStart = inVsync && !vsyncPrev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendingDepth <= DEPTH_W'(STACK_LIMIT);
      activeDepth  <= DEPTH_W'(STACK_LIMIT);
      background   <= '0;
      vsyncPrev    <= 1'b0;
    end else begin
      vsyncPrev <= inVsync;
      if (cfgWe && !cfgAddr && depthLegal)
        pendingDepth <= cfgWdata[DEPTH_W-1:0];
      if (cfgWe && cfgAddr)
        background <= cfgWdata;
      if (frameStart)
        activeDepth <= pendingDepth;
    end
  end

  // Timing delay for the raster controls, matched to the pixel pipeline
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DELAY; i++) syncPipe[i] <= '0;
    end else begin
      syncPipe[0] <= {inValid, inHsync, inVsync};
      for (int i = 1; i < DELAY; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end

  assign dpCtrl.depth      = activeDepth;
  assign dpCtrl.background = background;
  assign {outValid, outHsync, outVsync} = syncPipe[DELAY-1];

endmodule

// File: rtl/blend_select.sv
module blend_select
  import blend_pkg::*;
#(
  parameter int NUM_LAYERS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  dp_ctrl_t                    dpCtrl,
  input  logic [NUM_LAYERS-1:0]       layerActive,
  input  logic [NUM_LAYERS*PIX_W-1:0] layerColor,
  input  logic [NUM_LAYERS*CH_W-1:0]  layerAlpha,
  input  logic [NUM_LAYERS-1:0]       layerBlendEn,
  output slot_t [STACK_LIMIT-1:0]     slotsQ,
  output logic [PIX_W-1:0]            accQ
);

  localparam int IDX_W = $clog2(NUM_LAYERS);

  slot_t [STACK_LIMIT-1:0] slotsD;
  logic  [NUM_LAYERS-1:0]  remaining;
  logic  [IDX_W-1:0]       pick;
  logic                    found;
  logic                    belowValid;

  // Slot 0 takes the highest-index active layer, slot 1 the next, and so on
  always_comb begin
    slotsD     = '0;
    remaining  = layerActive;
    pick       = '0;
    found      = 1'b0;
    belowValid = 1'b0;
    for (int k = 0; k < STACK_LIMIT; k++) begin
      found = 1'b0;
      pick  = '0;
      for (int i = 0; i < NUM_LAYERS; i++) begin
        if (remaining[i]) begin
          found = 1'b1;
          pick  = IDX_W'(i);
        end
      end
      if (found && (k < int'(dpCtrl.depth))) begin
        slotsD[k].valid   = 1'b1;
        slotsD[k].color   = layerColor[pick*PIX_W +: PIX_W];
        slotsD[k].alpha   = layerAlpha[pick*CH_W +: CH_W];
        slotsD[k].blendEn = layerBlendEn[pick];
        remaining[pick]   = 1'b0;
      end
    end
    for (int k = STACK_LIMIT - 1; k >= 0; k--) begin
      slotsD[k].isBase = slotsD[k].valid && !belowValid;
      belowValid       = belowValid || slotsD[k].valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slotsQ <= '0;
      accQ   <= '0;
    end else begin
      slotsQ <= slotsD;
      accQ   <= dpCtrl.background;
    end
  end

endmodule

// File: rtl/blend_stage.sv
module blend_stage
  import blend_pkg::*;
#(
  parameter int SLOT_SEL = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  slot_t [STACK_LIMIT-1:0] slotsIn,
  input  logic [PIX_W-1:0]        accIn,
  output slot_t [STACK_LIMIT-1:0] slotsOut,
  output logic [PIX_W-1:0]        accOut
);

  slot_t            cur;
  logic [PIX_W-1:0] mixed;
  logic [PIX_W-1:0] accNext;

  assign cur = slotsIn[SLOT_SEL];

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    assign mixed[ch*CH_W +: CH_W] = blendChannel(cur.alpha,
                                                 cur.color[ch*CH_W +: CH_W],
                                                 accIn[ch*CH_W +: CH_W]);
  end

  always_comb begin
    accNext = accIn;
    if (cur.valid) begin
      if (cur.isBase || !cur.blendEn) accNext = cur.color;
      else                            accNext = mixed;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slotsOut <= '0;
      accOut   <= '0;
    end else begin
      slotsOut <= slotsIn;
      accOut   <= accNext;
    end
  end

endmodule

// File: rtl/blend_datapath.sv
module blend_datapath
  import blend_pkg::*;
#(
  parameter int NUM_LAYERS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  dp_ctrl_t                    dpCtrl,
  input  logic [NUM_LAYERS-1:0]       layerActive,
  input  logic [NUM_LAYERS*PIX_W-1:0] layerColor,
  input  logic [NUM_LAYERS*CH_W-1:0]  layerAlpha,
  input  logic [NUM_LAYERS-1:0]       layerBlendEn,
  output logic [PIX_W-1:0]            pixelOut
);

  slot_t [STACK_LIMIT-1:0] slotChain [STACK_LIMIT+1];
  logic  [PIX_W-1:0]       accChain  [STACK_LIMIT+1];

  blend_select #(.NUM_LAYERS(NUM_LAYERS)) u_select (
    .clk         (clk),
    .rst_n       (rst_n),
    .dpCtrl      (dpCtrl),
    .layerActive (layerActive),
    .layerColor  (layerColor),
    .layerAlpha  (layerAlpha),
    .layerBlendEn(layerBlendEn),
    .slotsQ      (slotChain[0]),
    .accQ        (accChain[0])
  );

  // Stage s handles slot STACK_LIMIT-1-s: blending runs bottom to top
  for (genvar s = 0; s < STACK_LIMIT; s++) begin : g_stage
    blend_stage #(.SLOT_SEL(STACK_LIMIT - 1 - s)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .slotsIn (slotChain[s]),
      .accIn   (accChain[s]),
      .slotsOut(slotChain[s+1]),
      .accOut  (accChain[s+1])
    );
  end

  assign pixelOut = accChain[STACK_LIMIT];

endmodule

// File: rtl/pixel_blend_stack.sv
module pixel_blend_stack
  import blend_pkg::*;
#(
  parameter int NUM_LAYERS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfgWe,
  input  logic                        cfgAddr,
  input  logic [PIX_W-1:0]            cfgWdata,
  input  logic                        inValid,
  input  logic                        inHsync,
  input  logic                        inVsync,
  input  logic [NUM_LAYERS-1:0]       layerActive,
  input  logic [NUM_LAYERS*PIX_W-1:0] layerColor,
  input  logic [NUM_LAYERS*CH_W-1:0]  layerAlpha,
  input  logic [NUM_LAYERS-1:0]       layerBlendEn,
  output logic                        outValid,
  output logic                        outHsync,
  output logic                        outVsync,
  output logic [PIX_W-1:0]            outColor
);

  dp_ctrl_t dpCtrl;

  blend_control #(.DELAY(LATENCY)) u_control (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .cfgWdata(cfgWdata),
    .inValid (inValid),
    .inHsync (inHsync),
    .inVsync (inVsync),
    .dpCtrl  (dpCtrl),
    .outValid(outValid),
    .outHsync(outHsync),
    .outVsync(outVsync)
  );

  blend_datapath #(.NUM_LAYERS(NUM_LAYERS)) u_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .dpCtrl      (dpCtrl),
    .layerActive (layerActive),
    .layerColor  (layerColor),
    .layerAlpha  (layerAlpha),
    .layerBlendEn(layerBlendEn),
    .pixelOut    (outColor)
  );

endmodule

// File: rtl/blend_stack_checker.sv
module blend_stack_checker
  import blend_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               inValid,
  input logic               inHsync,
  input logic               inVsync,
  input logic               outValid,
  input logic               outHsync,
  input logic               outVsync,
  input logic [DEPTH_W-1:0] activeDepth
);

  logic [3:0] sinceReset;

  always_ff @(posedge clk) begin
    if (!rst_n) sinceReset <= '0;
    else if (sinceReset < 4'(LATENCY)) sinceReset <= sinceReset + 4'd1;
  end

  // R10: raster controls follow their inputs by the pipeline latency
  assert_valid_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceReset >= 4'(LATENCY)) |-> (outValid == $past(inValid, LATENCY)));
  assert_hsync_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceReset >= 4'(LATENCY)) |-> (outHsync == $past(inHsync, LATENCY)));
  assert_vsync_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceReset >= 4'(LATENCY)) |-> (outVsync == $past(inVsync, LATENCY)));

  // R8: the depth in use always lies in the legal range
  assert_depth_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (activeDepth >= DEPTH_W'(2)) && (activeDepth <= DEPTH_W'(STACK_LIMIT)));

  // R9: the depth in use changes only right after a vsync rising edge
  assert_depth_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(inVsync) |=> $stable(activeDepth));

endmodule

bind pixel_blend_stack blend_stack_checker u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .inValid    (inValid),
  .inHsync    (inHsync),
  .inVsync    (inVsync),
  .outValid   (outValid),
  .outHsync   (outHsync),
  .outVsync   (outVsync),
  .activeDepth(dpCtrl.depth)
);

// File: tb/pixel_blend_stack_test.sv
`timescale 1ns/1ps
module pixel_blend_stack_test;

  localparam int NL  = 32;
  localparam int LAT = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfgWe = 1'b0;
  logic            cfgAddr = 1'b0;
  logic [23:0]     cfgWdata = '0;
  logic            inValid = 1'b0;
  logic            inHsync = 1'b0;
  logic            inVsync = 1'b0;
  logic [NL-1:0]   layerActive = '0;
  logic [NL*24-1:0] layerColor = '0;
  logic [NL*8-1:0] layerAlpha = '0;
  logic [NL-1:0]   layerBlendEn = '0;
  logic            outValid;
  logic            outHsync;
  logic            outVsync;
  logic [23:0]     outColor;

  int          checks = 0;
  int          fails = 0;
  bit          finished = 1'b0;
  int          pendModel = 6;
  int          actModel = 6;
  logic [23:0] bgModel = '0;

  always #5 clk = ~clk;

  pixel_blend_stack uut (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .inValid(inValid), .inHsync(inHsync), .inVsync(inVsync),
    .layerActive(layerActive), .layerColor(layerColor), .layerAlpha(layerAlpha),
    .layerBlendEn(layerBlendEn), .outValid(outValid), .outHsync(outHsync),
    .outVsync(outVsync), .outColor(outColor)
  );

  task automatic checkEq(input string tag, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %06h expected %06h", tag, got, exp);
    end
  endtask

  function automatic logic [23:0] model(input logic [NL-1:0] act, input logic [NL*24-1:0] cols,
                                        input logic [NL*8-1:0] alps, input logic [NL-1:0] ens,
                                        input int depth, input logic [23:0] bg);
    int sel [8];
    int cnt = 0;
    logic [23:0] acc;
    for (int i = NL - 1; i >= 0; i--)
      if (act[i] && cnt < depth) begin sel[cnt] = i; cnt++; end
    if (cnt == 0) return bg;
    acc = cols[sel[cnt-1]*24 +: 24];
    for (int k = cnt - 2; k >= 0; k--) begin
      int l = sel[k];
      if (!ens[l]) acc = cols[l*24 +: 24];
      else begin
        int a = int'(alps[l*8 +: 8]);
        for (int ch = 0; ch < 3; ch++) begin
          int s = int'(cols[l*24 + ch*8 +: 8]);
          int d = int'(acc[ch*8 +: 8]);
          acc[ch*8 +: 8] = 8'((a * s + (255 - a) * d + 127) / 255);
        end
      end
    end
    return acc;
  endfunction

  task automatic cfgWrite(input logic addr, input logic [23:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = addr; cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0;
    if (!addr && data >= 2 && data <= 6) pendModel = int'(data);
    if (addr) bgModel = data;
  endtask

  task automatic pulseVsync();
    @(negedge clk);
    inVsync = 1'b1;
    @(negedge clk);
    inVsync = 1'b0;
    actModel = pendModel;
  endtask

  // density in 1/16 per layer; alphaMode 0 random, 1 only 0/255, 2 random with all blend-enabled
  task automatic runStream(input int n, input int density, input int alphaMode, input string tag);
    logic [23:0] expC [128];
    for (int j = 0; j < n + LAT; j++) begin
      @(negedge clk);
      if (j >= LAT) begin
        checkEq(tag, outColor, expC[j-LAT]);
        checkEq({tag, " R10 valid"}, {23'd0, outValid}, 24'd1);
      end
      if (j < n) begin
        for (int i = 0; i < NL; i++) begin
          layerActive[i] = (($urandom % 16) < density);
          layerColor[i*24 +: 24] = 24'($urandom);
          if (alphaMode == 1) layerAlpha[i*8 +: 8] = ($urandom % 2) ? 8'hFF : 8'h00;
          else layerAlpha[i*8 +: 8] = 8'($urandom);
          layerBlendEn[i] = (alphaMode == 2) ? 1'b1 : (($urandom % 4) != 0);
        end
        inValid = 1'b1;
        expC[j] = model(layerActive, layerColor, layerAlpha, layerBlendEn, actModel, bgModel);
      end else begin
        inValid = 1'b0;
        layerActive = '0;
      end
    end
  endtask

  task automatic runSync(input int n);
    logic [2:0] expS [128];
    for (int j = 0; j < n + LAT; j++) begin
      @(negedge clk);
      if (j >= LAT)
        checkEq("R10 sync alignment", {21'd0, outValid, outHsync, outVsync}, {21'd0, expS[j-LAT]});
      if (j < n) begin
        inValid = 1'($urandom); inHsync = 1'($urandom); inVsync = 1'($urandom);
        expS[j] = {inValid, inHsync, inVsync};
      end else begin
        inValid = 1'b0; inHsync = 1'b0; inVsync = 1'b0;
      end
    end
  endtask

  task automatic directPixel(input logic [NL-1:0] act, input logic [NL*24-1:0] cols,
                             input logic [NL*8-1:0] alps, input logic [NL-1:0] ens,
                             input logic [23:0] exp, input string tag);
    @(negedge clk);
    layerActive = act; layerColor = cols; layerAlpha = alps; layerBlendEn = ens;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; layerActive = '0;
    repeat (LAT - 1) @(negedge clk);
    checkEq(tag, outColor, exp);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    logic [NL*24-1:0] cols;
    logic [NL*8-1:0]  alps;
    // R11: outputs quiet in and right after reset
    repeat (4) @(negedge clk);
    checkEq("R11 reset color", outColor, 24'd0);
    checkEq("R11 reset syncs", {21'd0, outValid, outHsync, outVsync}, 24'd0);
    rst_n = 1'b1;
    @(negedge clk);
    checkEq("R11 post-reset color", outColor, 24'd0);
    checkEq("R11 post-reset syncs", {21'd0, outValid, outHsync, outVsync}, 24'd0);

    // R3 R2: lone active layer is opaque; inactive layers with colour do not leak
    cols = {NL{24'hFFFFFF}}; alps = '0;
    cols[3*24 +: 24] = 24'h0A0B0C;
    directPixel(32'h0000_0008, cols, alps, 32'hFFFF_FFFF, 24'h0A0B0C, "R3 R2 lone base");
    // R4: layer 31 at alpha 128 over base layer 0
    cols = '0; alps = '0;
    cols[31*24 +: 24] = 24'hFF0000; alps[31*8 +: 8] = 8'd128;
    cols[0 +: 24] = 24'h0000FF;
    directPixel(32'h8000_0001, cols, alps, 32'h8000_0001, 24'h80007F, "R4 half blend");
    // R5: blend-enable clear overwrites
    cols = '0; alps = '0;
    cols[10*24 +: 24] = 24'h112233; alps[10*8 +: 8] = 8'd50;
    cols[2*24 +: 24] = 24'hABCDEF;
    directPixel(32'h0000_0404, cols, alps, 32'h0000_0004, 24'h112233, "R5 overwrite");

    // R1 R2 R4 R5 R6 at default depth 6 (R8 reset depth)
    runStream(40, 10, 0, "R1 R8 default depth");
    // R7: no active layers give background
    cfgWrite(1'b1, 24'h123456);
    runStream(20, 0, 0, "R7 background");

    for (int d = 2; d <= 6; d++) begin
      cfgWrite(1'b0, 24'(d));
      runStream(20, 8, 0, "R9 old depth before vsync");
      pulseVsync();
      runStream(40, 12, 0, "R1 R4 R5 dense");
      runStream(40, 2, 0, "R6 sparse");
      runStream(30, 14, 1, "R3 alpha extremes");
      runStream(30, 16, 2, "R4 all blended");
      if (d == 2) begin
        // R1 R3: layer 5 must stay hidden at depth 2, base layer 6 ignores alpha 0
        cols = '0; alps = '0;
        cols[7*24 +: 24] = 24'h777777; cols[6*24 +: 24] = 24'h666666;
        cols[5*24 +: 24] = 24'h555555;
        directPixel(32'h0000_00E0, cols, alps, 32'h0000_00E0, 24'h666666, "R1 R3 depth two");
      end
    end

    // R8: illegal depths are ignored
    cfgWrite(1'b0, 24'd3);
    pulseVsync();
    cfgWrite(1'b0, 24'd7);
    cfgWrite(1'b0, 24'd1);
    cfgWrite(1'b0, 24'd0);
    cfgWrite(1'b0, 24'h000103);
    pulseVsync();
    runStream(40, 12, 0, "R8 illegal depth ignored");

    // R10: syncs stay aligned
    runSync(100);
    finish();
  end

endmodule